// File: doc/BRIEF.md
# Programmable Multi-Domain Clock Divider

This block turns one fast clock into a family of single-cycle clock enables for several on-chip domains. A free-running two-bit phase counter supplies two fixed rates. The engine rate is half the fast clock. The core/bus rate is a quarter of the fast clock, and the scratch, hash and register-access domain uses the same quarter rate. Each further domain counts engine ticks against its own divisor, which software loads through a single configuration write port. These domains are one per external memory channel, one peripheral-bus domain and one for the remaining units. Every output is a one-fast-cycle-high enable, and the receiving logic gates its registers with it.

A configuration write clamps each divisor field to its legal range before storing it. Each domain picks up its stored divisor only when its current division period ends, so a write never shortens or stretches the period already in progress. The peripheral-bus field counts in units of four engine ticks.

The six PLL-multiplier strap inputs are sampled while reset is held and are read back afterwards. The read-back value carries an error bit that flags an illegal code. Its top bit is the error flag and its low six bits are the captured code.

Top module: `clkdiv_fanout`

## Requirements
- R1: `eng_en` is high on every second fast cycle, first in the cycle after reset is released, so the engine rate is the fast clock divided by 2.
- R2: `core_en` is high on every fourth fast cycle, in the same cycle as every second `eng_en` pulse, so the core/bus rate is the fast clock divided by 4.
- R3: Memory channel i takes its divisor N from `cfg_wdata[4i+3:4i]`. `mem_en[i]` pulses once every N engine ticks, which is 2N fast cycles, and each channel is independent of the others.
- R4: The other-units divisor sits in `cfg_wdata[15:12]` and drives `misc_en`. Odd divisors from 3 to 15 give an exact period of 2N fast cycles, and every programmable output pulse is exactly one fast cycle wide and falls on an engine tick.
- R5: The peripheral-bus field `cfg_wdata[11:8]` is multiplied by 4, so a field value of F gives `pbus_en` a period of 4F engine ticks. A field value of 2 gives 16 fast cycles.
- R6: A memory or other-units field written below 3 is stored as 3, and a peripheral-bus field written below 2 is stored as 2.
- R7: After reset every programmable domain divides by 3, and the peripheral bus divides by 12 engine ticks (field 3).
- R8: A new divisor takes effect only after the pulse that ends the current period. The period running when the write happens keeps its old length.
- R9: `strap_mult` is captured on every cycle while reset is held and stays frozen afterwards. `mult_rd[5:0]` returns the code, and `mult_rd[6]` is set when the code is odd, below 16 or above 48.
- R10: While reset is held, all enable outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock from the PLL |
| rst | input | 1 | Synchronous active-high reset |
| strap_mult | input | 6 | PLL multiplier strap code, sampled during reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Divisor fields: memory channels, peripheral bus, other units |
| mult_rd | output | 7 | Captured strap code, with the illegal-code flag in bit 6 |
| eng_en | output | 1 | Engine-domain enable (fast / 2) |
| core_en | output | 1 | Core/bus and scratch-domain enable (fast / 4) |
| mem_en | output | 2 | Per-memory-channel enables |
| pbus_en | output | 1 | Peripheral-bus enable |
| misc_en | output | 1 | Other-units enable |

## Verification
The hardest case to reach is a divisor write that lands inside a running period. The old period must finish at its old length, and only the next period may use the new value. The stimulus first steps until a memory-channel pulse is seen, then writes a larger divisor on the very next cycle. It measures that the gap is still the old one and that the gap after it has the new length. A cycle-accurate behavioural model runs alongside and is compared on every cycle, so an early or late switch shows up at the exact cycle where it occurs.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int DIV_LO   = 3;
  localparam int PB_LO    = 2;
  localparam int PB_SHIFT = 2;
  localparam int STRAP_W  = 6;
  localparam int MULT_LO  = 16;
  localparam int MULT_HI  = 48;

  // raise a requested divisor to the lowest legal value
  function automatic int clamp_low(input int v, input int lo);
    return (v < lo) ? lo : v;
  endfunction

  // strap code is legal only when even and inside the multiplier range
  function automatic logic strap_illegal(input logic [STRAP_W-1:0] s);
    return s[0] || (int'(s) < MULT_LO) || (int'(s) > MULT_HI);
  endfunction
endpackage

// File: rtl/clkdiv_phase.sv
module clkdiv_phase (
  input  logic clk,
  input  logic rst,
  output logic eng_tick,
  output logic core_tick
);
  logic [1:0] ph;

  always_ff @(posedge clk) begin
    if (rst) ph <= '0;
    else     ph <= ph + 2'd1;
  end

  assign eng_tick  = ph[0];
  assign core_tick = &ph;

  // R1
  eng_alt_chk: assert property (@(posedge clk) disable iff (rst)
    eng_tick |=> !eng_tick);

  // R1
  eng_ret_chk: assert property (@(posedge clk) disable iff (rst)
    !eng_tick |=> eng_tick);

  // R2
  core_gap_chk: assert property (@(posedge clk) disable iff (rst)
    core_tick |=> !core_tick);
endmodule

// File: rtl/clkdiv_stage.sv
module clkdiv_stage #(
  parameter int CNT_W   = 4,
  parameter int RST_DIV = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] next_div,
  output logic             pulse
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] act;
  logic             at_end;

  assign at_end = (cnt == act - CNT_W'(1));
  assign pulse  = tick & at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      act <= CNT_W'(RST_DIV);
    end else if (tick) begin
      if (at_end) begin
        cnt <= '0;
        act <= next_div;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R8
  div_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (act != $past(act)) |-> $past(pulse));

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < act);

  // R4
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/clkdiv_strap.sv
module clkdiv_strap
  import clkdiv_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] strap,
  output logic [STRAP_W:0]   rd
);
  logic [STRAP_W-1:0] code;
  logic               bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= strap;
      bad  <= strap_illegal(strap);
    end
  end

  assign rd = {bad, code};

  // R9
  strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(rd));
endmodule

// File: rtl/clkdiv_fanout.sv
module clkdiv_fanout
  import clkdiv_pkg::*;
#(
  parameter int NUM_MEM = 2,
  parameter int FLD_W   = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [STRAP_W-1:0]           strap_mult,
  input  logic                         cfg_we,
  input  logic [FLD_W*(NUM_MEM+2)-1:0] cfg_wdata,
  output logic [STRAP_W:0]             mult_rd,
  output logic                         eng_en,
  output logic                         core_en,
  output logic [NUM_MEM-1:0]           mem_en,
  output logic                         pbus_en,
  output logic                         misc_en
);
  localparam int NDOM     = NUM_MEM + 2;
  localparam int PB_IDX   = NUM_MEM;
  localparam int MISC_IDX = NUM_MEM + 1;
  localparam int PB_W     = FLD_W + PB_SHIFT;

  logic [FLD_W-1:0] fld [NDOM];
  logic             eng_tick;
  logic             core_tick;

  clkdiv_phase u_phase (
    .clk       (clk),
    .rst       (rst),
    .eng_tick  (eng_tick),
    .core_tick (core_tick)
  );

  assign eng_en  = eng_tick;
  assign core_en = core_tick;

  // divisor fields are clamped on the way into storage
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int d = 0; d < NDOM; d++) fld[d] <= FLD_W'(DIV_LO);
    end else if (cfg_we) begin
      for (int d = 0; d < NDOM; d++)
        fld[d] <= FLD_W'(clamp_low(int'(cfg_wdata[d*FLD_W +: FLD_W]),
                                   (d == PB_IDX) ? PB_LO : DIV_LO));
    end
  end

  for (genvar g = 0; g < NUM_MEM; g++) begin : g_mem
    clkdiv_stage #(.CNT_W(FLD_W), .RST_DIV(DIV_LO)) u_mem (
      .clk      (clk),
      .rst      (rst),
      .tick     (eng_tick),
      .next_div (fld[g]),
      .pulse    (mem_en[g])
    );
  end

  clkdiv_stage #(.CNT_W(PB_W), .RST_DIV(DIV_LO << PB_SHIFT)) u_pbus (
    .clk      (clk),
    .rst      (rst),
    .tick     (eng_tick),
    .next_div ({fld[PB_IDX], {PB_SHIFT{1'b0}}}),
    .pulse    (pbus_en)
  );

  clkdiv_stage #(.CNT_W(FLD_W), .RST_DIV(DIV_LO)) u_misc (
    .clk      (clk),
    .rst      (rst),
    .tick     (eng_tick),
    .next_div (fld[MISC_IDX]),
    .pulse    (misc_en)
  );

  clkdiv_strap u_strap (
    .clk   (clk),
    .rst   (rst),
    .strap (strap_mult),
    .rd    (mult_rd)
  );

  // R6
  mem_floor_chk: assert property (@(posedge clk) disable iff (rst)
    int'(fld[0]) >= DIV_LO);

  // R6
  pb_floor_chk: assert property (@(posedge clk) disable iff (rst)
    int'(fld[PB_IDX]) >= PB_LO);

  // R10
  quiet_rst_chk: assert property (@(posedge clk)
    $past(rst) |-> !(eng_en || core_en || pbus_en || misc_en || (|mem_en)));
endmodule

// File: tb/clkdiv_fanout_test.sv
module clkdiv_fanout_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  strap = 6'd32;
  logic        we = 1'b0;
  logic [15:0] wd = '0;
  logic [6:0]  rd;
  logic        eng, core, pb, misc;
  logic [1:0]  mem;

  clkdiv_fanout uut (
    .clk        (clk),
    .rst        (rst),
    .strap_mult (strap),
    .cfg_we     (we),
    .cfg_wdata  (wd),
    .mult_rd    (rd),
    .eng_en     (eng),
    .core_en    (core),
    .mem_en     (mem),
    .pbus_en    (pb),
    .misc_en    (misc)
  );

  always #10 clk = ~clk;

  int   n_chk = 0;
  int   n_fail = 0;
  int   m_ph;
  int   m_cnt [4];
  int   m_act [4];
  int   m_cfg [4];
  logic seen  [4];

  // domain 2 is the peripheral bus: floor 2, four engine ticks per unit
  function automatic int lim(input int raw, input int d);
    int v;
    if (d == 2) begin
      v = raw;
      if (v < 2) v = 2;
      return v * 4;
    end
    v = raw;
    if (v < 3) v = 3;
    return v;
  endfunction

  function automatic string dname(input int d);
    if (d == 0) return "R3 mem_en[0]";
    if (d == 1) return "R3 mem_en[1]";
    if (d == 2) return "R5 pbus_en";
    return "R4 misc_en";
  endfunction

  task automatic chk(input string tag, input int a, input int e);
    n_chk++;
    if (a != e) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, a, e);
    end
  endtask

  task automatic model_reset();
    m_ph = 0;
    for (int d = 0; d < 4; d++) begin
      m_cnt[d] = 0;
      m_act[d] = lim(3, d);
      m_cfg[d] = lim(3, d);
    end
  endtask

  // compare this cycle's outputs, then advance the model across the next edge
  task automatic eval(input logic w, input logic [15:0] data);
    logic e_eng;
    we = w;
    wd = data;
    seen[0] = mem[0];
    seen[1] = mem[1];
    seen[2] = pb;
    seen[3] = misc;
    e_eng = (m_ph % 2) == 1;
    chk("R1 eng_en", int'(eng), int'(e_eng));
    chk("R2 core_en", int'(core), (m_ph == 3) ? 1 : 0);
    for (int d = 0; d < 4; d++)
      chk(dname(d), int'(seen[d]), (e_eng && (m_cnt[d] == m_act[d] - 1)) ? 1 : 0);
    if (e_eng) begin
      for (int d = 0; d < 4; d++) begin
        if (m_cnt[d] == m_act[d] - 1) begin
          m_cnt[d] = 0;
          m_act[d] = m_cfg[d];
        end else begin
          m_cnt[d]++;
        end
      end
    end
    if (w) for (int d = 0; d < 4; d++) m_cfg[d] = lim(int'(data[4*d +: 4]), d);
    m_ph = (m_ph + 1) % 4;
  endtask

  task automatic cyc(input logic w, input logic [15:0] data);
    @(negedge clk);
    eval(w, data);
  endtask

  task automatic do_reset(input logic [5:0] s);
    int e;
    @(negedge clk);
    rst = 1'b1;
    strap = s;
    we = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 outputs during reset", int'({eng, core, mem, pb, misc}), 0);
    end
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    eval(1'b0, '0);
    e = int'(s);
    if ((e % 2) != 0 || e < 16 || e > 48) e += 64;
    chk("R9 strap readback", int'(rd), e);
  endtask

  task automatic gap(input int d, output int g);
    cyc(1'b0, '0);
    for (int i = 0; i < 300 && !seen[d]; i++) cyc(1'b0, '0);
    g = 0;
    do begin
      cyc(1'b0, '0);
      g++;
    end while (!seen[d] && g < 300);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, '0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int g;
    do_reset(6'd32);

    // R7 defaults
    gap(0, g); chk("R7 default mem0 period", g, 6);
    gap(2, g); chk("R7 default pbus period", g, 24);
    gap(3, g); chk("R7 default misc period", g, 6);

    // misc=15 pbus=2 mem1=5 mem0=1 (clamped to 3)
    cyc(1'b1, 16'hF251);
    idle(80);
    gap(0, g); chk("R6 mem0 field 1 clamped to 3", g, 6);
    gap(1, g); chk("R3 mem1 divisor 5", g, 10);
    gap(2, g); chk("R5 pbus field 2 scaled", g, 16);
    gap(3, g); chk("R4 misc odd divisor 15", g, 30);

    // R8: write just after a mem0 pulse; running period keeps old length
    cyc(1'b0, '0);
    for (int i = 0; i < 300 && !seen[0]; i++) cyc(1'b0, '0);
    cyc(1'b1, 16'hF259);
    g = 1;
    while (!seen[0] && g < 300) begin
      cyc(1'b0, '0);
      g++;
    end
    chk("R8 period in progress unchanged", g, 6);
    g = 0;
    do begin
      cyc(1'b0, '0);
      g++;
    end while (!seen[0] && g < 300);
    chk("R8 new divisor after boundary", g, 18);

    // R6: floors on every field kind
    cyc(1'b1, 16'h0050);
    idle(80);
    gap(2, g); chk("R6 pbus field 0 clamped to 2", g, 16);
    gap(3, g); chk("R6 misc field 0 clamped to 3", g, 6);
    gap(0, g); chk("R6 mem0 field 0 clamped to 3", g, 6);
    gap(1, g); chk("R3 mem1 still 5", g, 10);

    // R9 strap codes
    do_reset(6'd33);
    do_reset(6'd14);
    do_reset(6'd50);
    do_reset(6'd48);
    strap = 6'd20;
    idle(10);
    chk("R9 readback frozen after reset", int'(rd), 48);
    gap(1, g); chk("R7 mem1 default after reset", g, 6);

    summary();
    $finish;
  end
endmodule